// File: doc/BRIEF.md
# Bank-Multiplexed Processor Bus Glue

This block sits between an 8-bit processor that extends its address to 24 bits and the memories and peripherals on the system bus. The processor does not have dedicated pins for the top address byte. In every bus cycle it places that byte on its data pins while its phase-2 clock is low. It then uses the same pins for real read or write data while phase 2 is high. The glue captures the bank byte during the low phase and combines it with the 16 address pins into a full 24-bit address.

The glue makes sure nothing else touches the shared data lines while the bank byte is on them. The memory output enable, the memory write enable and the enable of the data-bus transceiver are all held off whenever phase 2 is low. The transceiver separates the processor's pins from the system data bus. Its direction follows the read/write line.

The chip selects for RAM, ROM and three peripheral slots are decoded from the full address. They are deliberately not gated by phase 2, so a peripheral sees a stable select before phase 2 rises. All inputs are sampled on a fast system clock, and the bench models phase 2 from that clock.

Top module: `bank_bus_glue`

## Requirements
- R1: `mem_we_n` is high at every instant when `phi2` is low, including the moment just after `phi2` falls.
- R2: `mem_oe_n` is high at every instant when `phi2` is low.
- R3: `xcvr_en_n` is high whenever `phi2` is low. It is low while `phi2` is high in a cycle where `data_cycle` or `prog_cycle` was high.
- R4: `xcvr_dir` is 1 (system toward processor) after a clock edge that sampled `rwb` high, and 0 (processor toward system) after one that sampled `rwb` low. This holds in either phase.
- R5: `addr_out[23:16]` is updated from `cpu_data` on each clock edge that samples `phi2` low. It holds the last captured value through the whole high phase, even when `cpu_data` changes. `addr_out[15:0]` is `addr_lo` delayed by one clock.
- R6: While `phi2` is high, `mem_oe_n` is low exactly when the sampled cycle is valid, `rwb` is high, and RAM or ROM is selected. `mem_oe_n` and `mem_we_n` are never low together.
- R7: While `phi2` is high, `mem_we_n` is low exactly when the sampled cycle is valid, `rwb` is low, and RAM is selected. A write to ROM gives no write strobe.
- R8: RAM (`ram_cs_n` low) covers banks 0x00 to 0x7F, except 0x00D000 to 0x00FFFF. Banks 0x80 to 0xFF select nothing. At most one select is active at a time.
- R9: ROM (`rom_cs_n` low) covers 0x00E000 to 0x00FFFF.
- R10: The peripheral window covers 0x00D000 to 0x00DFFF. Address bits [11:10] give the slot: slots 0, 1 and 2 drive `io_cs_n[0]`, `io_cs_n[1]` and `io_cs_n[2]` low, and slot 3 selects nothing. The same offsets in any bank other than 0x00 decode as RAM, or as nothing above bank 0x7F.
- R11: All selects and `xcvr_dir` are registered one clock after their inputs, without any `phi2` term. They are settled before `phi2` rises and stay unchanged through the high phase.
- R12: When `data_cycle` and `prog_cycle` are both low, every select, both memory strobes and the transceiver enable stay inactive. The bank byte is still captured.
- R13: A synchronous active-high `rst` clears the bank and low address to 0, makes every select and enable inactive, and sets `xcvr_dir` to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock that samples all inputs |
| rst | input | 1 | Synchronous active-high reset |
| phi2 | input | 1 | Processor phase-2 clock, synchronous to clk |
| rwb | input | 1 | Processor read (1) / write (0) line |
| data_cycle | input | 1 | Valid data-access cycle flag |
| prog_cycle | input | 1 | Valid program-fetch cycle flag |
| addr_lo | input | 16 | Processor address pins |
| cpu_data | input | 8 | Processor data pins; bank byte while phi2 is low |
| addr_out | output | 24 | Captured bank byte and registered low address |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| xcvr_en_n | output | 1 | Data-bus transceiver enable, active low |
| xcvr_dir | output | 1 | Transceiver direction, 1 = toward processor |
| ram_cs_n | output | 1 | RAM chip select, active low |
| rom_cs_n | output | 1 | ROM chip select, active low |
| io_cs_n | output | 3 | Peripheral slot selects, active low |

## Verification
The hardest case to reach is the falling edge of `phi2` right after a write cycle. At that moment the registered qualifiers still hold the previous cycle's write intent, and only the phase term can keep the strobe off. Each scenario task therefore samples `mem_we_n`, `mem_oe_n` and `xcvr_en_n` a couple of nanoseconds after every `phi2` fall, before any clock edge has updated the qualifiers. The tasks also change `cpu_data` to a write or read value during the high phase, which shows whether the captured bank byte really holds. Slot 3 of the peripheral window and the same offsets in nonzero banks are driven on purpose to reach the decode corners.

// File: rtl/bank_bus_glue_pkg.sv
`timescale 1ns/1ps
package bank_bus_glue_pkg;

  typedef enum logic {
    XDIR_TO_SYS = 1'b0,
    XDIR_TO_CPU = 1'b1
  } xcvr_dir_e;

  typedef struct packed {
    logic rd;
    logic valid;
  } cyc_qual_t;

endpackage

// File: rtl/bank_capture.sv
`timescale 1ns/1ps
module bank_capture #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              phi2,
  input  logic [DATA_W-1:0] cpu_data,
  input  logic [ADDR_W-1:0] addr_lo,
  output logic [DATA_W-1:0] bank_next,
  output logic [DATA_W-1:0] bank_q,
  output logic [ADDR_W-1:0] addr_q
);

  // Transparent-while-low behaviour, expressed as a clock enable
  assign bank_next = phi2 ? bank_q : cpu_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_q <= '0;
      addr_q <= '0;
    end else begin
      bank_q <= bank_next;
      addr_q <= addr_lo;
    end
  end

  // R5: bank byte frozen across consecutive high-phase samples
  p_bank_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (phi2 && $past(phi2) && !$past(rst)) |-> $stable(bank_q));

endmodule

// File: rtl/addr_decode.sv
`timescale 1ns/1ps
module addr_decode #(
  parameter int                DATA_W        = 8,
  parameter int                ADDR_W        = 16,
  parameter int                NUM_IO        = 3,
  parameter logic [DATA_W-1:0] RAM_LAST_BANK = 8'h7F,
  parameter logic [ADDR_W-1:0] IO_BASE       = 16'hD000,
  parameter int                IO_SIZE       = 4096,
  parameter logic [ADDR_W-1:0] ROM_BASE      = 16'hE000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] bank,
  input  logic [ADDR_W-1:0] addr_lo,
  input  logic              valid,
  output logic              ram_sel,
  output logic              rom_sel,
  output logic [NUM_IO-1:0] io_sel
);

  localparam int                IO_SLOT_W = $clog2(NUM_IO + 1);
  localparam int                IO_SPAN_W = $clog2(IO_SIZE);
  localparam int                SLOT_LSB  = IO_SPAN_W - IO_SLOT_W;
  localparam logic [ADDR_W-1:0] IO_LAST   = ADDR_W'(IO_BASE + IO_SIZE - 1);

  logic                 in_bank0;
  logic                 rom_hit;
  logic                 io_hit;
  logic                 ram_hit;
  logic [IO_SLOT_W-1:0] slot;
  logic [NUM_IO-1:0]    io_hit_vec;

  assign in_bank0 = (bank == '0);
  assign rom_hit  = in_bank0 && (addr_lo >= ROM_BASE);
  assign io_hit   = in_bank0 && (addr_lo >= IO_BASE) && (addr_lo <= IO_LAST);
  assign ram_hit  = (bank <= RAM_LAST_BANK) && !rom_hit && !io_hit;
  assign slot     = IO_SLOT_W'((addr_lo - IO_BASE) >> SLOT_LSB);

  for (genvar g = 0; g < NUM_IO; g++) begin : g_io_slot
    assign io_hit_vec[g] = io_hit && (slot == IO_SLOT_W'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ram_sel <= 1'b0;
      rom_sel <= 1'b0;
      io_sel  <= '0;
    end else begin
      ram_sel <= valid && ram_hit;
      rom_sel <= valid && rom_hit;
      io_sel  <= valid ? io_hit_vec : '0;
    end
  end

  // R8: selects never overlap
  p_sel_onehot_r8: assert property (@(posedge clk) disable iff (rst)
    $countones({ram_sel, rom_sel, io_sel}) <= 1);

  // R12: an idle cycle leaves every select off
  p_idle_nosel_r12: assert property (@(posedge clk) disable iff (rst)
    !valid |=> !(ram_sel || rom_sel || (|io_sel)));

endmodule

// File: rtl/strobe_gen.sv
`timescale 1ns/1ps
module strobe_gen
  import bank_bus_glue_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic phi2,
  input  logic rwb,
  input  logic valid,
  input  logic ram_sel,
  input  logic rom_sel,
  output logic mem_oe_n,
  output logic mem_we_n,
  output logic xcvr_en_n,
  output logic xcvr_dir
);

  cyc_qual_t qual_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      qual_q <= '{rd: 1'b1, valid: 1'b0};
    end else begin
      qual_q <= '{rd: rwb, valid: valid};
    end
  end

  // Registered qualifiers, final single-gate phase term
  assign mem_oe_n  = ~(phi2 & qual_q.valid &  qual_q.rd & (ram_sel | rom_sel));
  assign mem_we_n  = ~(phi2 & qual_q.valid & ~qual_q.rd & ram_sel);
  assign xcvr_en_n = ~(phi2 & qual_q.valid);
  assign xcvr_dir  = qual_q.rd ? XDIR_TO_CPU : XDIR_TO_SYS;

  // R1
  p_we_gated_r1: assert property (@(posedge clk) disable iff (rst)
    !phi2 |-> mem_we_n);
  // R2
  p_oe_gated_r2: assert property (@(posedge clk) disable iff (rst)
    !phi2 |-> mem_oe_n);
  // R3
  p_xcvr_gated_r3: assert property (@(posedge clk) disable iff (rst)
    !phi2 |-> xcvr_en_n);
  // R6
  p_oe_we_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(!mem_oe_n && !mem_we_n));
  // R7
  p_we_ram_only_r7: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (ram_sel && !rom_sel));

endmodule

// File: rtl/bank_bus_glue.sv
`timescale 1ns/1ps
module bank_bus_glue #(
  parameter int     DATA_W        = 8,
  parameter int     ADDR_W        = 16,
  parameter int     NUM_IO        = 3,
  parameter logic [DATA_W-1:0] RAM_LAST_BANK = 8'h7F,
  parameter logic [ADDR_W-1:0] IO_BASE       = 16'hD000,
  parameter int     IO_SIZE       = 4096,
  parameter logic [ADDR_W-1:0] ROM_BASE      = 16'hE000
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     phi2,
  input  logic                     rwb,
  input  logic                     data_cycle,
  input  logic                     prog_cycle,
  input  logic [ADDR_W-1:0]        addr_lo,
  input  logic [DATA_W-1:0]        cpu_data,
  output logic [DATA_W+ADDR_W-1:0] addr_out,
  output logic                     mem_oe_n,
  output logic                     mem_we_n,
  output logic                     xcvr_en_n,
  output logic                     xcvr_dir,
  output logic                     ram_cs_n,
  output logic                     rom_cs_n,
  output logic [NUM_IO-1:0]        io_cs_n
);

  logic              valid;
  logic [DATA_W-1:0] bank_next;
  logic [DATA_W-1:0] bank_q;
  logic [ADDR_W-1:0] addr_q;
  logic              ram_sel;
  logic              rom_sel;
  logic [NUM_IO-1:0] io_sel;

  assign valid = data_cycle | prog_cycle;

  bank_capture #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) u_capture (
    .clk       (clk),
    .rst       (rst),
    .phi2      (phi2),
    .cpu_data  (cpu_data),
    .addr_lo   (addr_lo),
    .bank_next (bank_next),
    .bank_q    (bank_q),
    .addr_q    (addr_q)
  );

  addr_decode #(
    .DATA_W        (DATA_W),
    .ADDR_W        (ADDR_W),
    .NUM_IO        (NUM_IO),
    .RAM_LAST_BANK (RAM_LAST_BANK),
    .IO_BASE       (IO_BASE),
    .IO_SIZE       (IO_SIZE),
    .ROM_BASE      (ROM_BASE)
  ) u_decode (
    .clk     (clk),
    .rst     (rst),
    .bank    (bank_next),
    .addr_lo (addr_lo),
    .valid   (valid),
    .ram_sel (ram_sel),
    .rom_sel (rom_sel),
    .io_sel  (io_sel)
  );

  strobe_gen u_strobe (
    .clk       (clk),
    .rst       (rst),
    .phi2      (phi2),
    .rwb       (rwb),
    .valid     (valid),
    .ram_sel   (ram_sel),
    .rom_sel   (rom_sel),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .xcvr_en_n (xcvr_en_n),
    .xcvr_dir  (xcvr_dir)
  );

  assign addr_out = {bank_q, addr_q};
  assign ram_cs_n = ~ram_sel;
  assign rom_cs_n = ~rom_sel;
  assign io_cs_n  = ~io_sel;

  // R11: selects do not move inside the high phase
  p_sel_stable_r11: assert property (@(posedge clk) disable iff (rst)
    (phi2 && $past(phi2) && $stable(addr_lo) && $stable(data_cycle) && $stable(prog_cycle)
     && !$past(rst)) |=> $stable({ram_cs_n, rom_cs_n, io_cs_n}));

endmodule

// File: tb/bank_bus_glue_tb_top.sv
`timescale 1ns/1ps
module bank_bus_glue_tb_top;

  localparam int LOW_CLKS  = 4;
  localparam int HIGH_CLKS = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        phi2 = 1'b1;
  logic        rwb = 1'b1;
  logic        data_cycle = 1'b0;
  logic        prog_cycle = 1'b0;
  logic [15:0] addr_lo = '0;
  logic [7:0]  cpu_data = '0;
  logic [23:0] addr_out;
  logic        mem_oe_n, mem_we_n, xcvr_en_n, xcvr_dir;
  logic        ram_cs_n, rom_cs_n;
  logic [2:0]  io_cs_n;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  bank_bus_glue dut_i (
    .clk(clk), .rst(rst), .phi2(phi2), .rwb(rwb),
    .data_cycle(data_cycle), .prog_cycle(prog_cycle),
    .addr_lo(addr_lo), .cpu_data(cpu_data), .addr_out(addr_out),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .xcvr_en_n(xcvr_en_n), .xcvr_dir(xcvr_dir),
    .ram_cs_n(ram_cs_n), .rom_cs_n(rom_cs_n), .io_cs_n(io_cs_n)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // {ram, rom, io[2:0]} active high
  function automatic logic [4:0] exp_sel(input logic [7:0] bank,
                                         input logic [15:0] a, input bit v);
    if (!v) return 5'b0;
    if (bank == 8'h00 && a >= 16'hE000) return 5'b01000;
    if (bank == 8'h00 && a[15:12] == 4'hD) begin
      case (a[11:10])
        2'd0: return 5'b00001;
        2'd1: return 5'b00010;
        2'd2: return 5'b00100;
        default: return 5'b00000;
      endcase
    end
    if (bank <= 8'h7F) return 5'b10000;
    return 5'b0;
  endfunction

  function automatic logic [4:0] act_sel();
    return {~ram_cs_n, ~rom_cs_n, ~io_cs_n};
  endfunction

  task automatic run_cycle(input string req, input logic [7:0] bank,
                           input logic [15:0] a, input bit rd,
                           input bit dv, input bit pv, input logic [7:0] hi_data);
    logic [4:0] es;
    bit v;
    bit oe_exp, we_exp;
    v  = dv | pv;
    es = exp_sel(bank, a, v);
    oe_exp = v && rd && (es[4] || es[3]);
    we_exp = v && !rd && es[4];
    @(negedge clk);
    phi2 = 1'b0; addr_lo = a; rwb = rd;
    data_cycle = dv; prog_cycle = pv; cpu_data = bank;
    #2;
    chk(mem_we_n,  "R1", {req, " we at phi2 fall"}, mem_we_n, 1);
    chk(mem_oe_n,  "R2", {req, " oe at phi2 fall"}, mem_oe_n, 1);
    chk(xcvr_en_n, "R3", {req, " xcvr at phi2 fall"}, xcvr_en_n, 1);
    for (int i = 0; i < LOW_CLKS; i++) begin
      @(posedge clk); #2;
      chk(mem_we_n && mem_oe_n, "R1", {req, " strobes low phase"},
          {mem_we_n, mem_oe_n}, 2'b11);
      chk(xcvr_en_n, "R3", {req, " xcvr low phase"}, xcvr_en_n, 1);
    end
    chk(act_sel() == es, "R11", {req, " selects before phi2 rise"}, act_sel(), es);
    chk(xcvr_dir == rd, "R4", {req, " dir"}, xcvr_dir, rd);
    @(negedge clk);
    phi2 = 1'b1; cpu_data = hi_data;
    #2;
    chk(mem_oe_n == !oe_exp, "R6", {req, " oe high phase"}, mem_oe_n, !oe_exp);
    chk(mem_we_n == !we_exp, "R7", {req, " we high phase"}, mem_we_n, !we_exp);
    chk(xcvr_en_n == !v, "R3", {req, " xcvr high phase"}, xcvr_en_n, !v);
    for (int i = 0; i < HIGH_CLKS; i++) begin
      @(posedge clk); #2;
      chk(addr_out == {bank, a}, "R5", {req, " full address"}, addr_out, {bank, a});
      chk(act_sel() == es, "R11", {req, " selects high phase"}, act_sel(), es);
      chk(!(mem_oe_n == 1'b0 && mem_we_n == 1'b0), "R6", {req, " exclusive"},
          {mem_oe_n, mem_we_n}, 2'b11);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1; phi2 = 1'b1; data_cycle = 1'b1; rwb = 1'b0;
    addr_lo = 16'h1234; cpu_data = 8'h5A;
    repeat (3) @(posedge clk);
    #2;
    chk(addr_out == 24'h0, "R13", "addr in reset", addr_out, 0);
    chk(act_sel() == 5'b0, "R13", "selects in reset", act_sel(), 0);
    chk(mem_oe_n && mem_we_n && xcvr_en_n, "R13", "enables in reset",
        {mem_oe_n, mem_we_n, xcvr_en_n}, 3'b111);
    chk(xcvr_dir == 1'b1, "R13", "dir in reset", xcvr_dir, 1);
    @(negedge clk);
    rst = 1'b0; data_cycle = 1'b0; rwb = 1'b1;
  endtask

  task automatic t_ram();
    run_cycle("R8 ram read",  8'h12, 16'h3456, 1, 1, 0, 8'hA5);
    run_cycle("R7 ram write", 8'h12, 16'h3457, 0, 1, 0, 8'h3C);
    run_cycle("R8 ram top",   8'h7F, 16'hFFFF, 0, 1, 0, 8'h11);
  endtask

  task automatic t_rom();
    run_cycle("R9 rom fetch", 8'h00, 16'hE000, 1, 0, 1, 8'hEA);
    run_cycle("R9 rom data",  8'h00, 16'hFFFC, 1, 1, 0, 8'h00);
    run_cycle("R7 rom write", 8'h00, 16'hF123, 0, 1, 0, 8'h77);
    run_cycle("R8 ram below", 8'h00, 16'hCFFF, 1, 1, 0, 8'h77);
  endtask

  task automatic t_io();
    run_cycle("R10 slot0 rd", 8'h00, 16'hD000, 1, 1, 0, 8'h01);
    run_cycle("R10 slot1 wr", 8'h00, 16'hD5AA, 0, 1, 0, 8'h02);
    run_cycle("R10 slot2 rd", 8'h00, 16'hDBFF, 1, 1, 0, 8'h03);
    run_cycle("R10 slot3",    8'h00, 16'hDC00, 0, 1, 0, 8'h04);
    run_cycle("R10 bank5 ram", 8'h05, 16'hD400, 1, 1, 0, 8'h05);
  endtask

  task automatic t_high_banks();
    run_cycle("R8 bank80", 8'h80, 16'h0000, 1, 1, 0, 8'h80);
    run_cycle("R8 bankFF", 8'hFF, 16'hE000, 0, 1, 0, 8'hFF);
  endtask

  task automatic t_idle();
    run_cycle("R12 idle",  8'h33, 16'h2000, 1, 0, 0, 8'hCC);
    run_cycle("R12 idle w", 8'h00, 16'hE000, 0, 0, 0, 8'h99);
  endtask

  task automatic t_dir_low_phase();
    // R4: direction tracks rwb while phi2 is low, no phase term
    @(negedge clk);
    phi2 = 1'b0; rwb = 1'b0; data_cycle = 1'b1; cpu_data = 8'h21; addr_lo = 16'h0100;
    @(posedge clk); #2;
    chk(xcvr_dir == 1'b0, "R4", "dir write low phase", xcvr_dir, 0);
    @(negedge clk); rwb = 1'b1;
    @(posedge clk); #2;
    chk(xcvr_dir == 1'b1, "R4", "dir read low phase", xcvr_dir, 1);
    chk(addr_out[23:16] == 8'h21, "R5", "bank tracks low phase", addr_out[23:16], 8'h21);
    @(negedge clk); cpu_data = 8'h42;
    @(posedge clk); #2;
    chk(addr_out[23:16] == 8'h42, "R5", "bank follows data low", addr_out[23:16], 8'h42);
  endtask

  initial begin
    t_reset();
    t_ram();
    t_rom();
    t_io();
    t_high_banks();
    t_idle();
    t_dir_low_phase();
    run_cycle("R5 back to back", 8'h6E, 16'h8001, 0, 1, 0, 8'hF0);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #4_000_000;
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule